// File: doc/BRIEF.md
# LED Scroll and Toggle Controller

This block drives four active-high LED outputs from four debounced button press pulses. Out of reset it runs a scroll: one lit LED moves one position per scroll step. A scroll step is taken on every `STEP_DIV`-th assertion of the step tick input, so the input clock enable and the prescaler parameter together set the scroll speed. The first press on any button stops the scroll and puts the block into toggle mode. In toggle mode each later press flips the LED that belongs to that button.

An inactivity timer is reloaded by every press. When it runs out with no press, the block goes back to scrolling from the position where the scroll stopped. The timeout is `TIMEOUT_CYC` clock cycles; the default is about five seconds at 3.33 MHz. The upper four bits of the timer are brought out so that a debug display can show them.

Two debug controls sit on top of this behaviour. A direction input reverses the scroll. An override input makes the LEDs show the virtual switch bits XOR the virtual pushbutton bits, whatever the mode, so a pushbutton inverts its LED only while it is held.

Top module: `led_scroll_toggle_ctrl`

## Requirements
- R1: After reset, `led_o` is 4'b0001 (bit 0 lit, a 1 lights an LED), the block is in scroll mode and `idle_cnt_o` is 0.
- R2: In scroll mode with `scroll_dir_i` low, every `STEP_DIV`-th `step_tick_i` moves the lit bit from bit i to bit i+1, and bit 3 wraps to bit 0. Ticks between those steps leave `led_o` unchanged.
- R3: In scroll mode with `scroll_dir_i` high, each scroll step moves the lit bit from bit i to bit i-1, and bit 0 wraps to bit 3.
- R4: A press on any bit of `press_i` while in scroll mode enters toggle mode and clears the toggle state to 4'b0000. That press flips no LED.
- R5: In toggle mode, `led_o` shows the toggle state. A press on bit N flips LED N, several bits may flip in the same cycle, and `step_tick_i` has no effect.
- R6: Every press reloads the timer to `TIMEOUT_CYC`-1. If no press follows, the block returns to scroll mode on the `TIMEOUT_CYC`-th clock edge after the last press and resumes from the frozen scroll position.
- R7: A press in the same cycle that the timer would expire keeps the block in toggle mode and is applied as a toggle.
- R8: While `override_i` is high, `led_o` equals `vsw_i` XOR `vbtn_i` in both modes. Presses are still applied to the hidden state and show once `override_i` goes low.
- R9: `idle_cnt_o` carries the four most significant bits of the timer count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| press_i | input | 4 | One-cycle debounced press pulse per button |
| step_tick_i | input | 1 | Clock enable feeding the scroll prescaler |
| scroll_dir_i | input | 1 | 0 scrolls upward, 1 scrolls downward |
| override_i | input | 1 | 1 hands the LEDs to the virtual controls |
| vsw_i | input | 4 | Virtual switch levels |
| vbtn_i | input | 4 | Virtual pushbutton levels |
| led_o | output | 4 | LED drives, 1 lights |
| idle_cnt_o | output | 4 | Upper bits of the inactivity timer |

## Verification
A wrong mode bit shows on `led_o` in the same cycle, as a one-hot scroll pattern where a toggle pattern was expected or the reverse. The bench tells the two apart by keeping the frozen scroll position different from the toggle state. A timer that is off by one shows only at the expiry edge, so the bench samples the cycle just before the expiry and the cycle just after it. It also presses on the exact expiry cycle. A prescaler or rotation fault shows after at most `STEP_DIV` ticks, as a step taken at the wrong time or in the wrong direction.

// File: rtl/ledctl_pkg.sv
package ledctl_pkg;

    localparam int LED_N = 4;

    typedef enum logic {
        MODE_SCROLL = 1'b0,
        MODE_TOGGLE = 1'b1
    } led_mode_e;

    typedef struct packed {
        logic             dir_down;
        logic             override;
        logic [LED_N-1:0] vsw;
        logic [LED_N-1:0] vbtn;
    } vio_t;

    // one position of a circular one-hot walk
    function automatic logic [LED_N-1:0] rot_step(input logic [LED_N-1:0] v,
                                                  input logic             down);
        logic [LED_N-1:0] r;
        if (down) r = {v[0], v[LED_N-1:1]};
        else      r = {v[LED_N-2:0], v[LED_N-1]};
        return r;
    endfunction

endpackage

// File: rtl/led_step_gen.sv
module led_step_gen #(
    parameter int STEP_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic tick_i,
    output logic step_o
);
    localparam int DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(STEP_DIV - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (en_i && tick_i)
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end

    assign step_o = en_i && tick_i && (div_q == LAST);

    // R2
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        div_q <= LAST);

    // R2
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(en_i && tick_i) |=> $stable(div_q));

endmodule

// File: rtl/led_idle_timer.sv
module led_idle_timer #(
    parameter int TIMEOUT_CYC = 16_650_000,
    parameter int CNT_W       = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             press_any_i,
    input  logic             active_i,
    output logic             expire_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (press_any_i)
            cnt_q <= RELOAD;
        else if (active_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = active_i && !press_any_i && (cnt_q == '0);
    assign cnt_o    = cnt_q;

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        press_any_i |=> cnt_q == RELOAD);

    // R6
    countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (!press_any_i && active_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/led_pattern.sv
module led_pattern
    import ledctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LED_N-1:0] press_i,
    input  logic             step_i,
    input  logic             dir_down_i,
    input  logic             expire_i,
    output led_mode_e        mode_o,
    output logic [LED_N-1:0] pos_o,
    output logic [LED_N-1:0] tog_o
);
    led_mode_e        mode_q;
    logic [LED_N-1:0] pos_q;
    logic [LED_N-1:0] tog_q;
    logic             press_any;

    assign press_any = |press_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_SCROLL;
            pos_q  <= LED_N'(1);
            tog_q  <= '0;
        end else begin
            if (press_any)
                mode_q <= MODE_TOGGLE;
            else if (expire_i)
                mode_q <= MODE_SCROLL;

            if (mode_q == MODE_SCROLL && step_i)
                pos_q <= rot_step(pos_q, dir_down_i);

            if (press_any)
                tog_q <= (mode_q == MODE_SCROLL) ? '0 : (tog_q ^ press_i);
        end
    end

    assign mode_o = mode_q;
    assign pos_o  = pos_q;
    assign tog_o  = tog_q;

    // R2
    pos_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(pos_q) == 1);

    // R3
    down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SCROLL && step_i && dir_down_i && pos_q[0]) |=> pos_q[LED_N-1]);

    // R4
    enter_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SCROLL && press_any) |=> (tog_q == '0 && mode_q == MODE_TOGGLE));

    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_TOGGLE) |=> $stable(pos_q));

    // R5
    flip_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_TOGGLE && press_any) |=> tog_q == ($past(tog_q) ^ $past(press_i)));

    // R7
    press_wins_chk: assert property (@(posedge clk) disable iff (rst)
        press_any |=> mode_q == MODE_TOGGLE);

endmodule

// File: rtl/led_scroll_toggle_ctrl.sv
module led_scroll_toggle_ctrl
    import ledctl_pkg::*;
#(
    parameter int TIMEOUT_CYC = 16_650_000,
    parameter int STEP_DIV    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] press_i,
    input  logic       step_tick_i,
    input  logic       scroll_dir_i,
    input  logic       override_i,
    input  logic [3:0] vsw_i,
    input  logic [3:0] vbtn_i,
    output logic [3:0] led_o,
    output logic [3:0] idle_cnt_o
);
    localparam int RAW_W = $clog2(TIMEOUT_CYC);
    localparam int CNT_W = (RAW_W < 4) ? 4 : RAW_W;

    vio_t             vio;
    led_mode_e        mode;
    logic [LED_N-1:0] pos;
    logic [LED_N-1:0] tog;
    logic             step;
    logic             expire;
    logic [CNT_W-1:0] cnt;

    assign vio = '{dir_down: scroll_dir_i, override: override_i,
                   vsw: vsw_i, vbtn: vbtn_i};

    led_step_gen #(.STEP_DIV(STEP_DIV)) i_step (
        .clk    (clk),
        .rst    (rst),
        .en_i   (mode == MODE_SCROLL),
        .tick_i (step_tick_i),
        .step_o (step)
    );

    led_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) i_timer (
        .clk         (clk),
        .rst         (rst),
        .press_any_i (|press_i),
        .active_i    (mode == MODE_TOGGLE),
        .expire_o    (expire),
        .cnt_o       (cnt)
    );

    led_pattern i_pat (
        .clk        (clk),
        .rst        (rst),
        .press_i    (press_i),
        .step_i     (step),
        .dir_down_i (vio.dir_down),
        .expire_i   (expire),
        .mode_o     (mode),
        .pos_o      (pos),
        .tog_o      (tog)
    );

    always_comb begin
        if (vio.override)
            led_o = vio.vsw ^ vio.vbtn;
        else if (mode == MODE_SCROLL)
            led_o = pos;
        else
            led_o = tog;
    end

    assign idle_cnt_o = cnt[CNT_W-1 -: 4];

    // R6
    return_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> (mode == MODE_SCROLL && $stable(pos)));

    // R1
    scroll_led_chk: assert property (@(posedge clk) disable iff (rst)
        (!override_i && mode == MODE_SCROLL) |-> $countones(led_o) == 1);

endmodule

// File: tb/test_led_scroll_toggle_ctrl.sv
module test_led_scroll_toggle_ctrl;
    localparam int CLK_P = 10;
    localparam int TO    = 20;
    localparam int SD    = 2;
    localparam int NV    = 21;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] press = '0;
    logic       tick = 1'b0;
    logic       dir = 1'b0;
    logic       ovr = 1'b0;
    logic [3:0] vsw = '0;
    logic [3:0] vbtn = '0;
    logic [3:0] led;
    logic [3:0] idle;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    led_scroll_toggle_ctrl #(.TIMEOUT_CYC(TO), .STEP_DIV(SD)) i_led_scroll_toggle_ctrl (
        .clk(clk), .rst(rst), .press_i(press), .step_tick_i(tick),
        .scroll_dir_i(dir), .override_i(ovr), .vsw_i(vsw), .vbtn_i(vbtn),
        .led_o(led), .idle_cnt_o(idle)
    );

    // {press, tick, dir, ovr, vsw, vbtn, expected led}
    localparam logic [18:0] VEC [NV] = '{
        {4'b0000,1'b1,1'b0,1'b0,4'h0,4'h0,4'b0001}, // R2 first tick
        {4'b0000,1'b1,1'b0,1'b0,4'h0,4'h0,4'b0010}, // R2 step
        {4'b0000,1'b0,1'b0,1'b0,4'h0,4'h0,4'b0010}, // R2 no tick
        {4'b0000,1'b1,1'b0,1'b0,4'h0,4'h0,4'b0010},
        {4'b0000,1'b1,1'b0,1'b0,4'h0,4'h0,4'b0100},
        {4'b0000,1'b1,1'b0,1'b0,4'h0,4'h0,4'b0100},
        {4'b0000,1'b1,1'b0,1'b0,4'h0,4'h0,4'b1000},
        {4'b0000,1'b1,1'b0,1'b0,4'h0,4'h0,4'b1000},
        {4'b0000,1'b1,1'b0,1'b0,4'h0,4'h0,4'b0001}, // R2 wrap
        {4'b0000,1'b1,1'b1,1'b0,4'h0,4'h0,4'b0001}, // R3
        {4'b0000,1'b1,1'b1,1'b0,4'h0,4'h0,4'b1000}, // R3 wrap
        {4'b0000,1'b1,1'b1,1'b0,4'h0,4'h0,4'b1000},
        {4'b0000,1'b1,1'b1,1'b0,4'h0,4'h0,4'b0100},
        {4'b0000,1'b0,1'b0,1'b1,4'hA,4'h0,4'b1010}, // R8
        {4'b0000,1'b0,1'b0,1'b1,4'hA,4'h6,4'b1100}, // R8 xor
        {4'b0000,1'b0,1'b0,1'b0,4'hA,4'h6,4'b0100}, // R8 released
        {4'b0010,1'b0,1'b0,1'b0,4'h0,4'h0,4'b0000}, // R4 enter
        {4'b0010,1'b0,1'b0,1'b0,4'h0,4'h0,4'b0010}, // R5
        {4'b1001,1'b0,1'b0,1'b0,4'h0,4'h0,4'b1011}, // R5 multi
        {4'b0010,1'b0,1'b0,1'b0,4'h0,4'h0,4'b1001}, // R5
        {4'b0000,1'b1,1'b0,1'b0,4'h0,4'h0,4'b1001}  // R5 tick ignored
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] p, input logic t, input logic d,
                       input logic o, input logic [3:0] s, input logic [3:0] b);
        @(negedge clk);
        press = p; tick = t; dir = d; ovr = o; vsw = s; vbtn = b;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) cyc(4'b0000, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 led", led, 4'b0001);
        check("R1 idle", idle, 4'h0);
        @(negedge clk) rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            cyc(VEC[k][18:15], VEC[k][14], VEC[k][13], VEC[k][12], VEC[k][11:8], VEC[k][7:4]);
            check($sformatf("R2/R3/R4/R5/R8 vector %0d", k), led, VEC[k][3:0]);
        end

        // R9: count 19 after a press shows as 19>>1
        cyc(4'b0001, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0);
        check("R5 flip", led, 4'b1000);
        check("R9 idle after press", idle, 4'd9);
        idle_cycles(TO - 1);
        check("R6 still toggle before expiry", led, 4'b1000);
        check("R9 idle at zero", idle, 4'd0);
        // R7: press on the expiry cycle
        cyc(4'b0100, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0);
        check("R7 press at expiry", led, 4'b1100);
        check("R7 reload", idle, 4'd9);
        idle_cycles(TO - 1);
        check("R6 last toggle cycle", led, 4'b1100);
        idle_cycles(1);
        check("R6 back to scroll frozen pos", led, 4'b0100);
        cyc(4'b0000, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0);
        check("R2 resume half step", led, 4'b0100);
        cyc(4'b0000, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0);
        check("R2 resume step", led, 4'b1000);

        // R8 in toggle mode, presses applied under override
        cyc(4'b0001, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0);
        check("R4 entry clears", led, 4'b0000);
        cyc(4'b0000, 1'b0, 1'b0, 1'b1, 4'h3, 4'h1);
        check("R8 toggle mode override", led, 4'b0010);
        cyc(4'b0010, 1'b0, 1'b0, 1'b1, 4'hF, 4'h0);
        check("R8 override masks press", led, 4'b1111);
        cyc(4'b0000, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0);
        check("R8 hidden press shown", led, 4'b0010);

        // R1 reset mid-run
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1;
        check("R1 reset led", led, 4'b0001);
        check("R1 reset idle", idle, 4'h0);
        @(negedge clk) rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule